// File: doc/BRIEF.md
# ROT13 UDP Payload Stream Processor

This block sits in a word-wide packet stream between the layer that delimits UDP datagrams and the layer that rebuilds frames. Each clock it takes one 32-bit word together with a data-enable and four framing strobes: frame start, frame end, IP packet start and datagram start. It hands the same word and strobes out one clock later. Inside the UDP payload of a datagram, every byte that is an ASCII letter is rotated thirteen places through its own alphabet. All other bytes and words leave the block unchanged: cell and IP headers, the UDP header, the frame trailer and non-letter characters.

The rotation is its own inverse, so one instance scrambles a stream and a second instance restores it. All byte lanes of a word are handled in parallel. The UDP header length is a parameter counted in enabled words. The datagram-start word is header word zero.

Top module: `rot13_udp_stream`

## Requirements
- R1: Every output strobe (o_valid, o_sof, o_eof, o_sop, o_sod) equals the matching input strobe of the previous clock, and o_data is produced in that same cycle.
- R2: In a payload word, each uppercase byte 0x41..0x5A is replaced by the letter 13 places further on, wrapping within the alphabet (A->N, M->Z, N->A, Z->M).
- R3: In a payload word, each lowercase byte 0x61..0x7A is rotated the same way (a->n, m->z, n->a, z->m), so "Hello" becomes "Uryyb".
- R4: Payload bytes outside both letter ranges (for example 0x40, 0x5B, 0x60, 0x7B, digits) are passed unchanged, and all four byte lanes are treated independently.
- R5: The word carrying datagram-start and the next HDR_WORDS-1 enabled words (default 2 words in total) form the UDP header and are passed unchanged.
- R6: The payload runs from the first enabled word after the header up to and including the enabled word that carries end-of-frame. Cycles with i_valid low neither count nor end the region, and their data passes unchanged.
- R7: Enabled words after the end-of-frame word (the frame trailer) and any words before a datagram-start pass unchanged.
- R8: A datagram-start seen inside an active region restarts the header count at that word. A packet-start without datagram-start ends the region, so the following words pass unchanged.
- R9: While rst_n is low, all outputs are zero and the region is idle, so the first enabled word after reset passes unchanged unless it carries datagram-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_data | input | 32 | Stream data word |
| i_valid | input | 1 | Data-enable, word is meaningful |
| i_sof | input | 1 | Frame start strobe |
| i_eof | input | 1 | Frame end strobe, last payload word |
| i_sop | input | 1 | IP packet start strobe |
| i_sod | input | 1 | UDP datagram start strobe |
| o_data | output | 32 | Word after substitution, one clock later |
| o_valid | output | 1 | Delayed data-enable |
| o_sof | output | 1 | Delayed frame start |
| o_eof | output | 1 | Delayed frame end |
| o_sop | output | 1 | Delayed packet start |
| o_sod | output | 1 | Delayed datagram start |

## Verification
The bench aims at the letter boundaries A, M, N, Z, a, m, n, z and their neighbours @, [, ` and {. An off-by-one range test or a wrong wrap would corrupt punctuation or miss the edge letters. It inserts idle gaps inside the header and the payload, since a design that counted raw cycles would start the payload early or close it at a gap. It also restarts a datagram in mid-payload and ends one with a bare packet-start. A tracker that ignored these would scramble the new UDP header or keep rotating data that is not UDP. Random frames with letter-heavy bytes and trailer words then check every output word against a reference model.

// File: rtl/rot13_pkg.sv
package rot13_pkg;

  localparam int BYTE_W = 8;

  // Where the stream currently is relative to a UDP datagram
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_HDR  = 2'd1,
    SEG_PAY  = 2'd2
  } seg_e;

  function automatic logic is_upper(input logic [BYTE_W-1:0] b);
    return (b >= 8'h41) && (b <= 8'h5A);
  endfunction

  function automatic logic is_lower(input logic [BYTE_W-1:0] b);
    return (b >= 8'h61) && (b <= 8'h7A);
  endfunction

  function automatic logic is_letter(input logic [BYTE_W-1:0] b);
    return is_upper(b) || is_lower(b);
  endfunction

  // First half of each alphabet moves up by 13, second half moves down by 13
  function automatic logic [BYTE_W-1:0] rot13_byte(input logic [BYTE_W-1:0] b);
    logic first_half;
    first_half = (b >= 8'h41 && b <= 8'h4D) || (b >= 8'h61 && b <= 8'h6D);
    if (!is_letter(b))
      return b;
    else if (first_half)
      return b + 8'd13;
    else
      return b - 8'd13;
  endfunction

endpackage

// File: rtl/udp_payload_tracker.sv
module udp_payload_tracker
  import rot13_pkg::*;
#(
  parameter int HDR_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic sop,
  input  logic sod,
  input  logic eof,
  output logic in_pay
);

  localparam int CW = $clog2(HDR_WORDS + 1);

  seg_e          seg_q, seg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hdr_last;

  assign hdr_last = (cnt_q == CW'(HDR_WORDS - 1));

  always_comb begin
    seg_d  = seg_q;
    cnt_d  = cnt_q;
    in_pay = 1'b0;
    if (valid) begin
      if (sod) begin
        seg_d = (HDR_WORDS == 1) ? SEG_PAY : SEG_HDR;
        cnt_d = CW'(1);
        if (eof) seg_d = SEG_IDLE;
      end else if (sop) begin
        seg_d = SEG_IDLE;
      end else begin
        case (seg_q)
          SEG_HDR: begin
            if (hdr_last) seg_d = SEG_PAY;
            else          cnt_d = cnt_q + 1'b1;
            if (eof) seg_d = SEG_IDLE;
          end
          SEG_PAY: begin
            in_pay = 1'b1;
            if (eof) seg_d = SEG_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_IDLE;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: the datagram-start word is header, never payload
  p_sod_is_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sod) |-> !in_pay);

  // R6: idle cycles inside the payload keep the region open
  p_gap_holds_pay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_PAY && !valid) |=> (seg_q == SEG_PAY));

  // R6: the end-of-frame word closes the region
  p_eof_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && eof) |=> (seg_q == SEG_IDLE));

  // R8: a bare packet-start leaves the stream outside any datagram
  p_sop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sop && !sod) |=> (seg_q == SEG_IDLE));

endmodule

// File: rtl/rot13_lane_xform.sv
module rot13_lane_xform
  import rot13_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic              en,
  output logic [DATA_W-1:0] dout
);

  localparam int LANES = DATA_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_in, lane_rot;
    assign lane_in  = din[g*BYTE_W +: BYTE_W];
    assign lane_rot = rot13_byte(lane_in);
    assign dout[g*BYTE_W +: BYTE_W] = en ? lane_rot : lane_in;
  end

endmodule

// File: rtl/rot13_udp_stream.sv
module rot13_udp_stream
  import rot13_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HDR_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] i_data,
  input  logic              i_valid,
  input  logic              i_sof,
  input  logic              i_eof,
  input  logic              i_sop,
  input  logic              i_sod,
  output logic [DATA_W-1:0] o_data,
  output logic              o_valid,
  output logic              o_sof,
  output logic              o_eof,
  output logic              o_sop,
  output logic              o_sod
);

  localparam int LANES = DATA_W / BYTE_W;

  logic              pay_now;   // current input word lies in the payload
  logic              pay_q;     // the word now on o_data was payload
  logic [DATA_W-1:0] xw;        // word after substitution

  udp_payload_tracker #(.HDR_WORDS(HDR_WORDS)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (i_valid),
    .sop    (i_sop),
    .sod    (i_sod),
    .eof    (i_eof),
    .in_pay (pay_now)
  );

  rot13_lane_xform #(.DATA_W(DATA_W)) u_xform (
    .din  (i_data),
    .en   (pay_now),
    .dout (xw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_data  <= '0;
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_eof   <= 1'b0;
      o_sop   <= 1'b0;
      o_sod   <= 1'b0;
      pay_q   <= 1'b0;
    end else begin
      o_data  <= xw;
      o_valid <= i_valid;
      o_sof   <= i_sof;
      o_eof   <= i_eof;
      o_sop   <= i_sop;
      o_sod   <= i_sod;
      pay_q   <= pay_now;
    end
  end

  // R1: strobes leave exactly one clock after they arrive
  p_strobe_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (o_valid == $past(i_valid) && o_sof == $past(i_sof) &&
                      o_eof == $past(i_eof) && o_sop == $past(i_sop) &&
                      o_sod == $past(i_sod)));

  // R7: any word outside the payload comes out bit-identical
  p_outside_intact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !pay_q) |-> (o_data == $past(i_data)));

  // R4: per lane, a letter stays a letter and a non-letter stays as it was
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_class_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (is_letter(o_data[g*BYTE_W +: BYTE_W]) ==
                        is_letter($past(i_data[g*BYTE_W +: BYTE_W]))));
    p_nonletter_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !is_letter($past(i_data[g*BYTE_W +: BYTE_W]))) |->
        (o_data[g*BYTE_W +: BYTE_W] == $past(i_data[g*BYTE_W +: BYTE_W])));
  end

endmodule

// File: tb/test_rot13_udp_stream.sv
`timescale 1ns/1ps
module test_rot13_udp_stream;

  localparam int HDR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] i_data = '0;
  logic        i_valid = 1'b0, i_sof = 1'b0, i_eof = 1'b0, i_sop = 1'b0, i_sod = 1'b0;
  logic [31:0] o_data;
  logic        o_valid, o_sof, o_eof, o_sop, o_sod;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // expectation pending from the previous driven word
  bit          pend = 1'b0;
  logic [31:0] exp_data;
  logic [4:0]  exp_strb;
  string       exp_tag;

  // reference region model
  int m_st = 0;   // 0 outside, 1 header, 2 payload
  int m_cnt = 0;

  always #4 clk = ~clk;

  rot13_udp_stream i_rot13_udp_stream (
    .clk(clk), .rst_n(rst_n), .i_data(i_data), .i_valid(i_valid),
    .i_sof(i_sof), .i_eof(i_eof), .i_sop(i_sop), .i_sod(i_sod),
    .o_data(o_data), .o_valid(o_valid), .o_sof(o_sof), .o_eof(o_eof),
    .o_sop(o_sop), .o_sod(o_sod)
  );

  function automatic logic [7:0] ref_byte(input logic [7:0] b);
    int base;
    if (b >= "A" && b <= "Z") base = 65;
    else if (b >= "a" && b <= "z") base = 97;
    else return b;
    return 8'(((int'(b) - base + 13) % 26) + base);
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = ref_byte(w[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      check({o_valid, o_sof, o_eof, o_sop, o_sod} == exp_strb, "R1",
            {27'd0, o_valid, o_sof, o_eof, o_sop, o_sod}, {27'd0, exp_strb});
      check(o_data == exp_data, exp_tag, o_data, exp_data);
    end
  endtask

  // one cycle of stimulus: check last word, drive this one, predict its output
  task automatic step(input bit v, input bit sf, input bit ef, input bit sp, input bit sd,
                      input logic [31:0] d, input string tag);
    bit pay;
    int prev;
    @(negedge clk);
    check_pending();
    i_valid = v; i_sof = sf; i_eof = ef; i_sop = sp; i_sod = sd; i_data = d;
    pay = 1'b0;
    prev = m_st;
    if (v) begin
      if (sd) begin
        m_st = (HDR == 1) ? 2 : 1; m_cnt = 1;
        if (ef) m_st = 0;
        prev = 1;
      end else if (sp) begin
        m_st = 0;
      end else if (m_st == 1) begin
        if (m_cnt == HDR - 1) m_st = 2; else m_cnt++;
        if (ef) m_st = 0;
      end else if (m_st == 2) begin
        pay = 1'b1;
        if (ef) m_st = 0;
      end
    end
    exp_data = pay ? ref_word(d) : d;
    exp_strb = {v, sf, ef, sp, sd};
    if (tag != "") exp_tag = tag;
    else exp_tag = pay ? "R2" : (prev == 1 ? "R5" : "R7");
    pend = 1'b1;
  endtask

  function automatic logic [7:0] rnd_byte();
    case ($urandom % 4)
      0: return 8'(8'h41 + $urandom % 26);
      1: return 8'(8'h61 + $urandom % 26);
      default: return 8'($urandom % 256);
    endcase
  endfunction

  function automatic logic [31:0] rnd_word();
    return {rnd_byte(), rnd_byte(), rnd_byte(), rnd_byte()};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset values
    check({o_data, o_valid, o_sof, o_eof, o_sop, o_sod} == '0, "R9",
          o_data, 32'd0);
    // R9: region idle after reset, letters untouched without a datagram start
    step(1, 0, 0, 0, 0, "abcd", "R9");
    step(1, 0, 0, 0, 0, "WXYZ", "R9");

    // R2/R3/R4 boundary letters inside one datagram
    step(1, 1, 0, 0, 0, 32'h4500_0030, "R7");
    step(1, 0, 0, 1, 1, "ABCD", "R5");
    step(1, 0, 0, 0, 0, "mnop", "R5");
    step(1, 0, 0, 0, 0, "AMNZ", "R2");
    step(1, 0, 0, 0, 0, "amnz", "R3");
    step(1, 0, 0, 0, 0, "Hell", "R3");
    step(1, 0, 0, 0, 0, "o!09", "R3");
    step(1, 0, 0, 0, 0, 32'h405B607B, "R4");
    step(1, 0, 0, 0, 0, "@z[A", "R4");
    step(1, 0, 1, 0, 0, "Last", "R6");
    step(1, 0, 0, 0, 0, "trlr", "R7");
    step(1, 0, 0, 0, 0, "TRLR", "R7");
    step(0, 0, 0, 0, 0, "idle", "R7");

    // R6: gaps inside header and payload
    step(1, 1, 0, 1, 1, "Head", "R5");
    step(0, 0, 0, 0, 0, "gapx", "R6");
    step(1, 0, 0, 0, 0, "hdr2", "R5");
    step(0, 0, 0, 0, 0, "gapy", "R6");
    step(1, 0, 0, 0, 0, "payl", "R6");
    step(0, 0, 0, 0, 0, "GAPZ", "R6");
    step(1, 0, 1, 0, 0, "Done", "R6");
    step(1, 0, 0, 0, 0, "tail", "R7");

    // R8: restart mid-payload, then a bare packet start
    step(1, 1, 0, 1, 1, "hdrA", "R8");
    step(1, 0, 0, 0, 0, "hdrB", "R8");
    step(1, 0, 0, 0, 0, "pay1", "R8");
    step(1, 0, 0, 1, 1, "newH", "R8");
    step(1, 0, 0, 0, 0, "newI", "R8");
    step(1, 0, 0, 0, 0, "pay2", "R8");
    step(1, 0, 0, 1, 0, "ipOn", "R8");
    step(1, 0, 0, 0, 0, "ipTx", "R8");
    step(1, 0, 1, 0, 0, "ipEn", "R8");

    // random frames
    for (int f = 0; f < 80; f++) begin
      int pre, npay;
      pre  = $urandom % 3;
      npay = $urandom % 6;
      step(1, 1, 0, 0, 0, rnd_word(), "");
      for (int k = 0; k < pre; k++) step(1, 0, 0, 0, 0, rnd_word(), "");
      step(1, 0, (npay == 0 && ($urandom % 2) == 0), 1, 1, rnd_word(), "");
      for (int k = 0; k <= npay; k++) begin
        if ($urandom % 4 == 0) step(0, 0, 0, 0, 0, rnd_word(), "");
        if ($urandom % 40 == 0) step(1, 0, 0, 1, 1, rnd_word(), "");
        step(1, 0, (k == npay), 0, 0, rnd_word(), "");
      end
      for (int k = 0; k < 2; k++) step(1, 0, 0, 0, 0, rnd_word(), "");
      step(0, 0, 0, 0, 0, rnd_word(), "");
    end

    @(negedge clk);
    check_pending();
    pend = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule